// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits beside the page-load controller of a byte-wide nonvolatile array and inspects every byte write the host issues. It looks for fixed address/data command sequences, keeps a write-protect flag, and decides for each incoming byte whether it may reach the array. Bytes that form part of a command are marked as such and are never stored.

A three-byte command (AA at 5555h, 55 at 2AAAh, A0 at 5555h) turns protection on. The same prefix also opens one page load for real data while protection is on. A six-byte command (AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 20@5555h) turns protection off. A change of the flag is committed only when the page controller reports the end of the programming cycle. When protected, an unauthorised write is suppressed, but the controller still runs its timed cycle as it would for any write. The controller's byte-load timeout tick closes the load period. It discards any half-entered command and withdraws the authorisation.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset `protect` is 0, and an ordinary byte write gives `byte_pass`=1 and `cmd_byte`=0.
- R2: The bytes AA@5555h, 55@2AAAh, A0@5555h, written in that order, each give `cmd_byte`=1 and `byte_pass`=0. After the next `cycle_done` pulse, `protect` reads 1.
- R3: `protect` changes only on the clock edge that registers a `cycle_done` pulse. An enable takes effect at that edge even when no data byte followed the command.
- R4: While `protect`=1, a byte write that has no completed command before it in the same load period gives `byte_pass`=0 and `cmd_byte`=0.
- R5: While `protect`=1, data bytes that follow a completed three-byte prefix in the same load period give `byte_pass`=1 and `cmd_byte`=0.
- R6: The six-byte disable sequence flags all six bytes with `cmd_byte`=1, and data bytes after it pass. `protect` reads 0 after the following `cycle_done`.
- R7: A `win_expire` pulse abandons a partly entered sequence. The next byte is then matched from the first step.
- R8: A byte that does not match the expected step sends the matcher back to idle and is not a command byte. If that byte is AA@5555h, it is taken as step one of a new sequence (`cmd_byte`=1).
- R9: A `win_expire` pulse ends the authorisation granted by a command. A later byte in protected mode is suppressed.
- R10: The command addresses are not reserved. A non-command value written to 5555h outside a sequence passes when unprotected.
- R11: When unprotected, data bytes that follow the enable prefix in the same load period pass, and `protect` stays 0 until `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe per host byte write |
| wr_addr | input | 15 | Compare address of the byte |
| wr_data | input | 8 | Data of the byte |
| win_expire | input | 1 | Byte-load window timeout tick; the load period is closed |
| cycle_done | input | 1 | End-of-programming-cycle pulse |
| protect | output | 1 | Write-protect flag |
| byte_pass | output | 1 | Byte with the current strobe may be stored |
| cmd_byte | output | 1 | Byte with the current strobe belongs to a command sequence |

## Verification
On every cycle, the embedded assertions check four things. The protect flag moves only on a `cycle_done` edge. A rise or fall of the flag is backed by a pending enable or disable. A timeout clears both the matcher and the authorisation. A restart byte lands the matcher on step one. The bench scenarios are needed for the full per-byte decisions. These include the exact bytes flagged during enable and disable, the suppression of unauthorised writes, data passing after a prefix, and mismatch recovery. They depend on the ordered history of writes and on when the flag is committed.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
    localparam int SEQ_AW = 15;
    localparam int SEQ_DW = 8;

    localparam logic [SEQ_AW-1:0] ADDR_HI = 15'h5555;
    localparam logic [SEQ_AW-1:0] ADDR_LO = 15'h2AAA;
    localparam logic [SEQ_DW-1:0] D_KEY1  = 8'hAA;
    localparam logic [SEQ_DW-1:0] D_KEY2  = 8'h55;
    localparam logic [SEQ_DW-1:0] D_ARM   = 8'hA0;
    localparam logic [SEQ_DW-1:0] D_EXT   = 8'h80;
    localparam logic [SEQ_DW-1:0] D_CLR   = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_EXT, ST_K1B, ST_K2B
    } step_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_EN, PEND_DIS
    } pend_e;

    function automatic logic pair_is(
        input logic [SEQ_AW-1:0] a, input logic [SEQ_DW-1:0] d,
        input logic [SEQ_AW-1:0] ea, input logic [SEQ_DW-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction
endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
    import wp_seq_pkg::*;
#(
    parameter int AW = SEQ_AW,
    parameter int DW = SEQ_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          abort,
    output logic          is_cmd,
    output logic          hit_en,
    output logic          hit_dis
);
    typedef struct packed {
        step_e step;
    } mst_t;

    mst_t  st_d, st_q;
    step_e cur;
    logic  key1;

    always_comb begin
        cur     = abort ? ST_IDLE : st_q.step;
        key1    = pair_is(addr, data, ADDR_HI, D_KEY1);
        st_d    = st_q;
        is_cmd  = 1'b0;
        hit_en  = 1'b0;
        hit_dis = 1'b0;
        st_d.step = cur;
        if (stb) begin
            is_cmd = 1'b1;
            unique case (cur)
                ST_K1: begin
                    if (pair_is(addr, data, ADDR_LO, D_KEY2)) st_d.step = ST_K2;
                    else if (key1)                            st_d.step = ST_K1;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
                ST_K2: begin
                    if (pair_is(addr, data, ADDR_HI, D_ARM)) begin
                        st_d.step = ST_IDLE;
                        hit_en    = 1'b1;
                    end else if (pair_is(addr, data, ADDR_HI, D_EXT)) st_d.step = ST_EXT;
                    else if (key1)                                   st_d.step = ST_K1;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
                ST_EXT: begin
                    if (key1) st_d.step = ST_K1B;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
                ST_K1B: begin
                    if (pair_is(addr, data, ADDR_LO, D_KEY2)) st_d.step = ST_K2B;
                    else if (key1)                            st_d.step = ST_K1;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
                ST_K2B: begin
                    if (pair_is(addr, data, ADDR_HI, D_CLR)) begin
                        st_d.step = ST_IDLE;
                        hit_dis   = 1'b1;
                    end else if (key1) st_d.step = ST_K1;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
                default: begin
                    if (key1) st_d.step = ST_K1;
                    else begin st_d.step = ST_IDLE; is_cmd = 1'b0; end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{step: ST_IDLE};
        else        st_q <= st_d;
    end

    // R7: a timeout with no byte leaves the matcher idle
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !stb) |=> (st_q.step == ST_IDLE));

    // R8: a key-one byte arriving mid-sequence lands on step one
    a_r8_restart_step1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !abort && st_q.step != ST_IDLE && st_q.step != ST_EXT &&
         addr == ADDR_HI && data == D_KEY1) |=> (st_q.step == ST_K1));
endmodule

// File: rtl/wp_protect_ctl.sv
module wp_protect_ctl
    import wp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic is_cmd,
    input  logic hit_en,
    input  logic hit_dis,
    input  logic win_expire,
    input  logic cycle_done,
    output logic auth_eff,
    output logic protect,
    output logic byte_pass
);
    typedef struct packed {
        logic  prot;
        logic  auth;
        pend_e pend;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        auth_eff = st_q.auth & ~win_expire;
        st_d     = st_q;
        if (win_expire || cycle_done) st_d.auth = 1'b0;
        if (cycle_done) begin
            if (st_q.pend == PEND_EN)  st_d.prot = 1'b1;
            if (st_q.pend == PEND_DIS) st_d.prot = 1'b0;
            st_d.pend = PEND_NONE;
        end
        if (hit_en) begin
            st_d.pend = PEND_EN;
            st_d.auth = 1'b1;
        end
        if (hit_dis) begin
            st_d.pend = PEND_DIS;
            st_d.auth = 1'b1;
        end
        byte_pass = wr_stb & ~is_cmd & (~st_q.prot | auth_eff);
        protect   = st_q.prot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{prot: 1'b0, auth: 1'b0, pend: PEND_NONE};
        else        st_q <= st_d;
    end

    // R3: the flag moves only on a cycle-end edge
    a_r3_flag_at_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot != $past(st_q.prot)) |-> $past(cycle_done));

    // R2: a rise needs a pending enable
    a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.prot) |-> $past(st_q.pend == PEND_EN));

    // R6: a fall needs a pending disable
    a_r6_fall_needs_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.prot) |-> $past(st_q.pend == PEND_DIS));

    // R9: a timeout without a fresh command clears the authorisation
    a_r9_expire_drops_auth: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expire && !hit_en && !hit_dis) |=> !st_q.auth);
endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
    import wp_seq_pkg::*;
#(
    parameter int AW = SEQ_AW,
    parameter int DW = SEQ_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          win_expire,
    input  logic          cycle_done,
    output logic          protect,
    output logic          byte_pass,
    output logic          cmd_byte
);
    logic auth_eff, m_stb, m_cmd, m_en, m_dis;

    assign m_stb    = wr_stb & ~auth_eff;
    assign cmd_byte = m_cmd;

    wp_seq_matcher #(.AW(AW), .DW(DW)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (m_stb),
        .addr   (wr_addr),
        .data   (wr_data),
        .abort  (win_expire),
        .is_cmd (m_cmd),
        .hit_en (m_en),
        .hit_dis(m_dis)
    );

    wp_protect_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .is_cmd    (m_cmd),
        .hit_en    (m_en),
        .hit_dis   (m_dis),
        .win_expire(win_expire),
        .cycle_done(cycle_done),
        .auth_eff  (auth_eff),
        .protect   (protect),
        .byte_pass (byte_pass)
    );
endmodule

// File: tb/wp_seq_detect_tb.sv
`timescale 1ns/1ps
module wp_seq_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_expire = 1'b0;
    logic        cycle_done = 1'b0;
    logic        protect, byte_pass, cmd_byte;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic  pass;
        logic  cmd;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    wp_seq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_expire(win_expire), .cycle_done(cycle_done),
        .protect(protect), .byte_pass(byte_pass), .cmd_byte(cmd_byte)
    );

    // monitor: compares each strobed byte against the scoreboard
    always @(negedge clk) begin
        if (wr_stb) begin
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty at strobe");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (byte_pass !== e.pass || cmd_byte !== e.cmd) begin
                    n_fail++;
                    $display("FAIL %s pass/cmd actual %b/%b expected %b/%b",
                             e.tag, byte_pass, cmd_byte, e.pass, e.cmd);
                end
            end
        end
    end

    task automatic put(input logic [14:0] a, input logic [7:0] d,
                       input logic ep, input logic ec, input string tag);
        exp_t e;
        e.pass = ep; e.cmd = ec; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic expire();
        @(posedge clk); #1; win_expire = 1'b1;
        @(posedge clk); #1; win_expire = 1'b0;
    endtask

    task automatic done();
        @(posedge clk); #1; cycle_done = 1'b1;
        @(posedge clk); #1; cycle_done = 1'b0;
    endtask

    task automatic chk_prot(input logic ep, input string tag);
        @(negedge clk);
        n_run++;
        if (protect !== ep) begin
            n_fail++;
            $display("FAIL %s protect actual %b expected %b", tag, protect, ep);
        end
    endtask

    task automatic prefix(input logic expect_pass, input string tag);
        put(15'h5555, 8'hAA, 1'b0, 1'b1, tag);
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, tag);
        put(15'h5555, 8'hA0, 1'b0, 1'b1, tag);
        if (expect_pass) ;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_prot(1'b0, "R1 reset");
        put(15'h0123, 8'h5A, 1'b1, 1'b0, "R1 plain write");
        put(15'h5555, 8'h12, 1'b1, 1'b0, "R10 non-command at 5555");

        // enable with trailing data, unprotected
        prefix(1'b0, "R2 enable byte");
        put(15'h0200, 8'h11, 1'b1, 1'b0, "R11 data after prefix");
        chk_prot(1'b0, "R11 before cycle end");
        expire();
        chk_prot(1'b0, "R3 after expire only");
        done();
        chk_prot(1'b1, "R2 protect set");

        // unauthorised write
        put(15'h0300, 8'h22, 1'b0, 1'b0, "R4 blocked write");
        expire(); done();
        chk_prot(1'b1, "R4 still protected");

        // authorised page
        prefix(1'b0, "R5 prefix byte");
        put(15'h0400, 8'h33, 1'b1, 1'b0, "R5 data 1");
        put(15'h0401, 8'h34, 1'b1, 1'b0, "R5 data 2");
        expire();
        put(15'h0402, 8'h35, 1'b0, 1'b0, "R9 after expiry");
        expire(); done();

        // abandoned partial sequence
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R7 step1");
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, "R7 step2");
        expire();
        put(15'h5555, 8'hA0, 1'b0, 1'b0, "R7 orphan step3");
        expire(); done();

        // restart on key-one mismatch
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 step1");
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, "R8 step2");
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 restart");
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, "R8 step2 again");
        put(15'h5555, 8'hA0, 1'b0, 1'b1, "R8 step3");
        put(15'h0600, 8'h44, 1'b1, 1'b0, "R8 data after restart");
        expire(); done();

        // plain mismatch
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 step1 b");
        put(15'h2AAA, 8'h77, 1'b0, 1'b0, "R8 mismatch");
        put(15'h2AAA, 8'h55, 1'b0, 1'b0, "R8 idle after mismatch");
        expire(); done();
        chk_prot(1'b1, "R3 enable again holds");

        // disable
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R6 d1");
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, "R6 d2");
        put(15'h5555, 8'h80, 1'b0, 1'b1, "R6 d3");
        put(15'h5555, 8'hAA, 1'b0, 1'b1, "R6 d4");
        put(15'h2AAA, 8'h55, 1'b0, 1'b1, "R6 d5");
        put(15'h5555, 8'h20, 1'b0, 1'b1, "R6 d6");
        put(15'h0700, 8'h66, 1'b1, 1'b0, "R6 data after disable");
        expire();
        chk_prot(1'b1, "R3 disable waits");
        done();
        chk_prot(1'b0, "R6 protect cleared");
        put(15'h0701, 8'h67, 1'b1, 1'b0, "R6 plain write unprotected");

        // enable with no data bytes
        prefix(1'b0, "R3 bare enable");
        expire(); done();
        chk_prot(1'b1, "R3 enable without data");

        repeat (2) @(posedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule